// File: doc/BRIEF.md
# LIN Slave Synch Break Detector

This block runs next to a UART receiver that is working as a LIN slave. Once per bit time, an external baud tick tells it to sample the serial line. A synch break is a long run of dominant (low) bit samples. When the run reaches the configured length, the block sets a sticky break flag. It raises an interrupt when that flag and an enable bit are both set. It can also issue a one-cycle request that clears the receiver's framing-error, overrun-error, parity-error and data-full flags.

The line is low for the whole break, so the receiver's own framing error comes first. In 8N1 framing it fires at the stop position, ahead of the break flag. A break may stay low well past the threshold. It still produces exactly one detection, at the threshold sample. The line must return high before another break can count.

A registered copy of the serial input goes to a capture unit, which uses it to time the edges of the synch field that follows the break.

Top module: `lin_brk_det`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `brk_flag`, `brk_irq`, `brk_evt` and `rx_clr` are 0 and `cap_sig` is 1.
- R2: With `lin_slave_mode`=1, the block counts consecutive ticks that sample `rxd_in`=0. The tick that completes `BRK_LEN` of them (default 11) sets `brk_flag` at that clock edge. After `BRK_LEN`-1 such ticks, `brk_flag` stays 0.
- R3: A tick that samples `rxd_in`=1 restarts the low-run count from zero.
- R4: While `lin_slave_mode`=0, every tick restarts the count and `brk_flag` never sets.
- R5: `brk_irq` is 1 exactly when `brk_flag`=1 and `brk_irq_en`=1.
- R6: `brk_flag` stays 1 until a cycle with `brk_flag_clr`=1 clears it at the next edge. If a detection and `brk_flag_clr` fall in the same cycle, the flag ends up 1.
- R7: A detection gives a one-cycle `brk_evt` pulse at the same edge that sets the flag. Further low ticks in the same low period give no further pulse. A high tick re-arms detection.
- R8: With `clr_on_brk`=1, a detection drives `rx_clr`=4'b1111 for that one cycle. Bit 3 clears the framing error, bit 2 the overrun error, bit 1 the parity error and bit 0 the data-full flag. With `clr_on_brk`=0, `rx_clr` stays 4'b0000.
- R9: `cap_sig` equals `rxd_in` as sampled at the previous clock edge, whether or not a tick is present.
- R10: Clock cycles with `bit_tick`=0 neither advance nor restart the low-run count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit time; the line is sampled on this cycle |
| rxd_in | input | 1 | Serial LIN line, low is dominant |
| lin_slave_mode | input | 1 | 1 when the UART runs in LIN slave mode |
| brk_irq_en | input | 1 | Break interrupt enable |
| clr_on_brk | input | 1 | 1 to clear the receiver status flags on a detection |
| brk_flag_clr | input | 1 | Software write that clears the break flag |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Break interrupt request |
| brk_evt | output | 1 | One-cycle pulse at each detection |
| rx_clr | output | 4 | Receiver flag clear pulse: [3] framing, [2] overrun, [1] parity, [0] data-full |
| cap_sig | output | 1 | Registered copy of the line for the capture unit |

## Verification
The tick that completes the low run updates `brk_flag`, `brk_evt` and `rx_clr` at one clock edge. `cap_sig` follows the line one edge after it changes, and `brk_irq` follows the flag in the same cycle. A flag clear written in one cycle shows in the next. The bench drives each tick on a falling edge, drops it on the next falling edge, and compares every output against its own model at that point. That is the only cycle in which `brk_evt` and `rx_clr` are valid. One further idle cycle is then checked to confirm that those pulses have returned to zero.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    // Default number of consecutive low samples that make a synch break.
    localparam int unsigned BRK_LEN_DEF = 11;

    // Low-run tracker state: armed to detect, or spent until the line goes high.
    typedef enum logic {
        RUN_ARMED = 1'b0,
        RUN_SPENT = 1'b1
    } run_state_t;

    // Receiver status flags that a detection may clear.
    typedef struct packed {
        logic frame_err;
        logic ovr_err;
        logic par_err;
        logic data_full;
    } rx_clr_t;

    localparam rx_clr_t RX_CLR_NONE = '{frame_err: 1'b0, ovr_err: 1'b0, par_err: 1'b0, data_full: 1'b0};
    localparam rx_clr_t RX_CLR_ALL  = '{frame_err: 1'b1, ovr_err: 1'b1, par_err: 1'b1, data_full: 1'b1};

    // Counter width able to hold values 0 .. n-1.
    function automatic int unsigned run_cnt_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lin_brk_run.sv
module lin_brk_run
    import lin_brk_pkg::*;
#(
    parameter int unsigned BRK_LEN = BRK_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rxd_in,
    input  logic mode_en,
    output logic det_hit
);
    localparam int unsigned CNT_W = run_cnt_bits(BRK_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BRK_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    run_state_t       st_q;
    logic             low_smp;
    logic             restart;

    assign low_smp = bit_tick & ~rxd_in & mode_en;
    assign restart = bit_tick & (rxd_in | ~mode_en);
    assign det_hit = low_smp && (st_q == RUN_ARMED) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= RUN_ARMED;
        end else if (restart) begin
            cnt_q <= '0;
            st_q  <= RUN_ARMED;
        end else if (low_smp && st_q == RUN_ARMED) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                st_q  <= RUN_SPENT;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lin_brk_stat.sv
module lin_brk_stat
    import lin_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       det_hit,
    input  logic       flag_clr,
    input  logic       irq_en,
    input  logic       clr_cfg,
    output logic       flag_o,
    output logic       irq_o,
    output logic       evt_o,
    output logic [3:0] rx_clr_o
);
    logic    flag_q;
    logic    evt_q;
    rx_clr_t clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            evt_q  <= 1'b0;
            clr_q  <= RX_CLR_NONE;
        end else begin
            // a detection in the same cycle as a clear wins
            if (det_hit)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            evt_q <= det_hit;
            clr_q <= (det_hit && clr_cfg) ? RX_CLR_ALL : RX_CLR_NONE;
        end
    end

    assign flag_o   = flag_q;
    assign irq_o    = flag_q & irq_en;
    assign evt_o    = evt_q;
    assign rx_clr_o = clr_q;

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
    import lin_brk_pkg::*;
#(
    parameter int unsigned BRK_LEN = BRK_LEN_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       rxd_in,
    input  logic       lin_slave_mode,
    input  logic       brk_irq_en,
    input  logic       clr_on_brk,
    input  logic       brk_flag_clr,
    output logic       brk_flag,
    output logic       brk_irq,
    output logic       brk_evt,
    output logic [3:0] rx_clr,
    output logic       cap_sig
);
    logic det_hit;
    logic cap_q;

    lin_brk_run #(.BRK_LEN(BRK_LEN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .bit_tick(bit_tick),
        .rxd_in  (rxd_in),
        .mode_en (lin_slave_mode),
        .det_hit (det_hit)
    );

    lin_brk_stat u_stat (
        .clk     (clk),
        .rst     (rst),
        .det_hit (det_hit),
        .flag_clr(brk_flag_clr),
        .irq_en  (brk_irq_en),
        .clr_cfg (clr_on_brk),
        .flag_o  (brk_flag),
        .irq_o   (brk_irq),
        .evt_o   (brk_evt),
        .rx_clr_o(rx_clr)
    );

    // line copy for the capture unit; idle (recessive) level after reset
    always_ff @(posedge clk) begin
        if (rst) cap_q <= 1'b1;
        else     cap_q <= rxd_in;
    end
    assign cap_sig = cap_q;

endmodule

// File: rtl/lin_brk_det_chk.sv
module lin_brk_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       rxd_in,
    input logic       lin_slave_mode,
    input logic       clr_on_brk,
    input logic       brk_flag_clr,
    input logic       brk_flag,
    input logic       brk_evt,
    input logic [3:0] rx_clr
);
    // R2
    flag_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> brk_evt);

    // R4
    flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> $past(lin_slave_mode));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        brk_flag && !brk_flag_clr |=> brk_flag);

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_flag) |-> $past(brk_flag_clr));

    // R7
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> !brk_evt);

    // R8
    clr_only_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_clr != 4'b0000) |-> brk_evt);

    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt && $past(clr_on_brk) |-> rx_clr == 4'b1111);

    // R10
    evt_tick_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> $past(bit_tick) && !$past(rxd_in));

endmodule

bind lin_brk_det lin_brk_det_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_tick      (bit_tick),
    .rxd_in        (rxd_in),
    .lin_slave_mode(lin_slave_mode),
    .clr_on_brk    (clr_on_brk),
    .brk_flag_clr  (brk_flag_clr),
    .brk_flag      (brk_flag),
    .brk_evt       (brk_evt),
    .rx_clr        (rx_clr)
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb;
    localparam int BRK_LEN = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic       lin_slave_mode = 1'b1;
    logic       brk_irq_en = 1'b0;
    logic       clr_on_brk = 1'b0;
    logic       brk_flag_clr = 1'b0;
    logic       brk_flag, brk_irq, brk_evt, cap_sig;
    logic [3:0] rx_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_cnt   = 0;
    bit m_armed = 1'b1;
    bit m_flag  = 1'b0;
    bit m_hit   = 1'b0;

    always #2.5 clk = ~clk;

    lin_brk_det #(.BRK_LEN(BRK_LEN)) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rxd_in(rxd_in),
        .lin_slave_mode(lin_slave_mode), .brk_irq_en(brk_irq_en),
        .clr_on_brk(clr_on_brk), .brk_flag_clr(brk_flag_clr),
        .brk_flag(brk_flag), .brk_irq(brk_irq), .brk_evt(brk_evt),
        .rx_clr(rx_clr), .cap_sig(cap_sig)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_clr(input bit hit, input bit cfg);
        return (hit && cfg) ? 4'b1111 : 4'b0000;
    endfunction

    // model of one sampled bit (R2, R3, R4, R7)
    task automatic model_tick(input bit v);
        m_hit = lin_slave_mode && !v && m_armed && (m_cnt == BRK_LEN - 1);
        if (!lin_slave_mode || v) begin
            m_cnt = 0; m_armed = 1'b1;
        end else if (m_armed) begin
            if (m_cnt == BRK_LEN - 1) begin m_cnt = 0; m_armed = 1'b0; end
            else m_cnt++;
        end
    endtask

    // one bit: tick cycle (optionally with a flag clear), then an idle cycle
    task automatic send_bit(input bit v, input bit clr);
        @(negedge clk);
        rxd_in = v; bit_tick = 1'b1; brk_flag_clr = clr;
        model_tick(v);
        if (m_hit) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        @(negedge clk);
        bit_tick = 1'b0; brk_flag_clr = 1'b0;
        chk("R2/R6 flag", brk_flag, m_flag);
        chk("R5 irq", brk_irq, m_flag && brk_irq_en);
        chk("R7 evt", brk_evt, m_hit);
        chk("R8 rx_clr", rx_clr, exp_clr(m_hit, clr_on_brk));
        @(negedge clk);
        chk("R7 evt idle", brk_evt, 0);
        chk("R8 rx_clr idle", rx_clr, 0);
    endtask

    task automatic clear_flag();
        @(negedge clk); brk_flag_clr = 1'b1;
        @(negedge clk); brk_flag_clr = 1'b0; m_flag = 1'b0;
        chk("R6 cleared", brk_flag, 0);
        chk("R5 irq after clear", brk_irq, 0);
    endtask

    task automatic low_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
    endtask

    initial begin
        int run_left;
        bit lvl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 flag", brk_flag, 0); chk("R1 irq", brk_irq, 0);
        chk("R1 evt", brk_evt, 0); chk("R1 clr", rx_clr, 0);
        chk("R1 cap", cap_sig, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flag after", brk_flag, 0); chk("R1 cap after", cap_sig, 1);

        // R9: capture copy follows the line without ticks
        rxd_in = 1'b0; @(negedge clk); chk("R9 cap low", cap_sig, 0);
        rxd_in = 1'b1; @(negedge clk); chk("R9 cap high", cap_sig, 1);

        // R10: low line with no ticks does not count
        rxd_in = 1'b0; repeat (30) @(negedge clk);
        chk("R10 no tick", brk_flag, 0);
        // R2: 10 low ticks do not set, the 11th does
        brk_irq_en = 1'b1; clr_on_brk = 1'b1;
        low_run(BRK_LEN - 1);
        chk("R2 below threshold", brk_flag, 0);
        send_bit(1'b0, 1'b0);
        chk("R2 at threshold", brk_flag, 1);
        chk("R5 irq on", brk_irq, 1);
        // R7: long break gives no second event
        low_run(6);
        chk("R7 long break flag", brk_flag, 1);
        brk_irq_en = 1'b0; @(negedge clk); chk("R5 irq masked", brk_irq, 0);
        brk_irq_en = 1'b1;
        // R7: re-arm by a high sample
        send_bit(1'b1, 1'b0);
        clear_flag();
        clr_on_brk = 1'b0;
        low_run(BRK_LEN);
        chk("R7 rearmed", brk_flag, 1);
        // R6: detection and clear in the same cycle
        send_bit(1'b1, 1'b0);
        clear_flag();
        low_run(BRK_LEN - 1);
        send_bit(1'b0, 1'b1);
        chk("R6 set wins", brk_flag, 1);
        send_bit(1'b1, 1'b0);
        clear_flag();
        // R3: interrupted run
        low_run(BRK_LEN - 1); send_bit(1'b1, 1'b0); low_run(BRK_LEN - 1);
        chk("R3 restart", brk_flag, 0);
        send_bit(1'b1, 1'b0);
        // R4: outside LIN slave mode
        lin_slave_mode = 1'b0;
        low_run(BRK_LEN + 5);
        chk("R4 other mode", brk_flag, 0);
        lin_slave_mode = 1'b1;
        low_run(BRK_LEN - 1);
        chk("R4 mode restart", brk_flag, 0);
        send_bit(1'b1, 1'b0);

        // random phase
        run_left = 0; lvl = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (run_left == 0) begin
                lvl = ~lvl;
                run_left = lvl ? int'($urandom_range(1, 3)) : int'($urandom_range(1, 16));
            end
            if (i % 40 == 0) begin
                brk_irq_en     = $urandom_range(0, 1) != 0;
                clr_on_brk     = $urandom_range(0, 1) != 0;
                lin_slave_mode = $urandom_range(0, 9) != 0;
            end
            send_bit(lvl, $urandom_range(0, 19) == 0);
            run_left--;
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule